// File: doc/BRIEF.md
# Two-Wire Register Target with Pointer Replay

This block is the target side of a two-wire serial bus (I2C). It gives a master access to a small bank of 16-bit registers. It samples SCL and SDA through synchronizers and recognises START, repeated START and STOP. It compares the 7-bit target address and acknowledges valid bytes. It reaches the register bank through a plain address, read-data, write-strobe and write-data port. The bank itself sits outside the block. The block drives SDA only through an active-low pull-down enable, so the pin can be wired open-drain.

After the address byte comes a command byte. Its top bit marks a register read (1) or a write (0), and its low bits pick the register. A write sends two data bytes that the target commits as one word. A read closes the command phase with a repeated START and a read-direction address. The target then returns the word as two bytes. A shorter read is also available: a read-direction address with no command byte before it. That read replays the register that a full read selected most recently. This lets the master poll one register with three bytes per access instead of five.

Top module: `tw_reg_target`

## Requirements
- R1: A falling SDA while SCL is high (START or repeated START) starts a new address byte from any state. A rising SDA while SCL is high (STOP) releases SDA and puts the target in idle. Bits are taken most significant first, on the rising edge of SCL.
- R2: In the address byte, bits 7..1 are the target address and bit 0 is the direction (1 = read). When the address matches, the target pulls SDA low (sda_oe_n = 0) for the ninth SCL clock. The target only starts pulling while SCL is low.
- R3: After an address that does not match, the target sends no acknowledge, drives nothing and writes nothing until the next START or STOP.
- R4: The target acknowledges the command byte. Bit 7 of the command byte is the read flag, and its low REG_AW bits give the register address.
- R5: A command with bit 7 = 0 is followed by two data bytes, high byte first, and each is acknowledged. After the eighth bit of the second byte, rf_wr_en pulses for exactly one cycle with rf_wr_data = {first, second} at a stable rf_addr. If a STOP comes before the second byte is complete, nothing is written.
- R6: In a full read (address+W, read command, repeated START, address+R), the target sends the selected register high byte first. It changes SDA only while SCL is low.
- R7: If the master acknowledges the first data byte, the target sends the second. If the master does not acknowledge the first byte, the target releases SDA and sends nothing more, so the master reads ones.
- R8: A read-direction address that has no read command before it since the last STOP returns the register selected by the last full read. This pointer is register 0 after reset.
- R9: The replay pointer moves only when a read command is followed by an accepted read-direction address. A read command closed by STOP leaves the pointer unchanged, and so does any write.
- R10: While reset is held, sda_oe_n is 1 and rf_wr_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_oe_n | output | 1 | Active-low pull-down enable for SDA (0 = pull low) |
| rf_addr | output | REG_AW | Register bank address |
| rf_rd_data | input | 16 | Read data of the register at rf_addr |
| rf_wr_en | output | 1 | One-cycle register write strobe |
| rf_wr_data | output | 16 | Word to write |

## Verification
A STOP or repeated START can be detected in the same cycle that the byte logic would otherwise finish a phase: committing a write, or moving the replay pointer when a read direction is accepted. The bus events take priority. To provoke this, the bench ends a write with STOP right after its first data byte, and closes a read command with STOP before any read address. The result is judged at the ports: the register bank must show no new write, and a following short read must still return the register chosen by the earlier full read. It also issues a short read directly after reset, before any full read, and checks that register 0 comes back.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // phase of the byte engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_SACK,
        PH_TX,
        PH_MACK
    } phase_e;

    // meaning of the byte being received
    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_WHI,
        BY_WLO
    } byte_e;

    // what follows the acknowledge bit driven by the target
    typedef enum logic [2:0] {
        NX_CMD,
        NX_WHI,
        NX_WLO,
        NX_TX,
        NX_IDLE
    } next_e;

    // synchronized line view and bus events
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic byte_e kind_after(input next_e n);
        case (n)
            NX_CMD:  return BY_CMD;
            NX_WHI:  return BY_WHI;
            NX_WLO:  return BY_WLO;
            default: return BY_ADDR;
        endcase
    endfunction

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_ff;
    logic [TOP:0] sda_ff;
    logic         scl_q;
    logic         sda_q;

    // idle bus is high, so every stage resets to one
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[TOP-1:0], scl_in};
            sda_ff <= {sda_ff[TOP-1:0], sda_in};
            scl_q  <= scl_ff[TOP];
            sda_q  <= sda_ff[TOP];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[TOP];
        ev.sda      = sda_ff[TOP];
        ev.scl_rise = scl_ff[TOP] & ~scl_q;
        ev.scl_fall = ~scl_ff[TOP] & scl_q;
        ev.start    = scl_ff[TOP] & scl_q & sda_q & ~sda_ff[TOP];
        ev.stop     = scl_ff[TOP] & scl_q & ~sda_q & sda_ff[TOP];
    end

endmodule

// File: rtl/tw_byte_ctrl.sv
module tw_byte_ctrl
    import tw_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52,
    parameter int         REG_AW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_low,
    output logic [REG_AW-1:0] rf_addr,
    input  logic [WORD_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [WORD_W-1:0] rf_wr_data
);
    localparam int HB = BYTE_W - 1;

    phase_e             ph;
    byte_e              kind;
    next_e              nxt;
    logic [HB-1:0]      shreg;
    logic [2:0]         bitcnt;
    logic [REG_AW-1:0]  addr_q;
    logic [REG_AW-1:0]  last_q;
    logic               rd_cmd_q;
    logic [HB:0]        hi_q;
    logic [WORD_W-1:0]  txw;
    logic               byte_idx;
    logic               mack_ok;
    logic               sda_low_q;
    logic               wr_q;
    logic [WORD_W-1:0]  wdat_q;
    logic [HB:0]        rx_byte;

    assign rx_byte = {shreg, sda_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            kind      <= BY_ADDR;
            nxt       <= NX_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            addr_q    <= '0;
            last_q    <= '0;
            rd_cmd_q  <= 1'b0;
            hi_q      <= '0;
            txw       <= '0;
            byte_idx  <= 1'b0;
            mack_ok   <= 1'b0;
            sda_low_q <= 1'b0;
            wr_q      <= 1'b0;
            wdat_q    <= '0;
        end else begin
            wr_q <= 1'b0;
            if (stop_det) begin
                ph        <= PH_IDLE;
                sda_low_q <= 1'b0;
                rd_cmd_q  <= 1'b0;
            end else if (start_det) begin
                ph        <= PH_RX;
                kind      <= BY_ADDR;
                bitcnt    <= '0;
                sda_low_q <= 1'b0;
            end else begin
                case (ph)
                    PH_RX: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte[HB-1:0];
                            bitcnt <= 3'(bitcnt + 3'd1);
                            if (bitcnt == 3'd7) begin
                                ph <= PH_SACK;
                                case (kind)
                                    BY_ADDR: begin
                                        if (!addr_match(rx_byte, DEV_ADDR)) begin
                                            ph <= PH_IDLE;
                                        end else if (rx_byte[0]) begin
                                            nxt      <= NX_TX;
                                            rd_cmd_q <= 1'b0;
                                            if (rd_cmd_q) last_q <= addr_q;
                                            else          addr_q <= last_q;
                                        end else begin
                                            nxt <= NX_CMD;
                                        end
                                    end
                                    BY_CMD: begin
                                        addr_q <= rx_byte[REG_AW-1:0];
                                        if (rx_byte[HB]) begin
                                            rd_cmd_q <= 1'b1;
                                            nxt      <= NX_IDLE;
                                        end else begin
                                            rd_cmd_q <= 1'b0;
                                            nxt      <= NX_WHI;
                                        end
                                    end
                                    BY_WHI: begin
                                        hi_q <= rx_byte;
                                        nxt  <= NX_WLO;
                                    end
                                    default: begin
                                        wr_q   <= 1'b1;
                                        wdat_q <= {hi_q, rx_byte};
                                        nxt    <= NX_IDLE;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_SACK: begin
                        if (scl_fall) begin
                            if (!sda_low_q) begin
                                sda_low_q <= 1'b1;
                            end else begin
                                case (nxt)
                                    NX_TX: begin
                                        txw       <= rf_rd_data;
                                        sda_low_q <= ~rf_rd_data[WORD_W-1];
                                        bitcnt    <= '0;
                                        byte_idx  <= 1'b0;
                                        ph        <= PH_TX;
                                    end
                                    NX_IDLE: begin
                                        sda_low_q <= 1'b0;
                                        ph        <= PH_IDLE;
                                    end
                                    default: begin
                                        sda_low_q <= 1'b0;
                                        bitcnt    <= '0;
                                        kind      <= kind_after(nxt);
                                        ph        <= PH_RX;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            txw    <= txw << 1;
                            bitcnt <= 3'(bitcnt + 3'd1);
                            if (bitcnt == 3'd7) begin
                                sda_low_q <= 1'b0;
                                ph        <= PH_MACK;
                            end else begin
                                sda_low_q <= ~txw[WORD_W-2];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) mack_ok <= ~sda_lvl;
                        if (scl_fall) begin
                            if (!byte_idx && mack_ok) begin
                                byte_idx  <= 1'b1;
                                bitcnt    <= '0;
                                sda_low_q <= ~txw[WORD_W-1];
                                ph        <= PH_TX;
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_low    = sda_low_q;
    assign rf_addr    = addr_q;
    assign rf_wr_en   = wr_q;
    assign rf_wr_data = wdat_q;

endmodule

// File: rtl/tw_reg_target.sv
module tw_reg_target
    import tw_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         REG_AW      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe_n,
    output logic [REG_AW-1:0] rf_addr,
    input  logic [15:0]       rf_rd_data,
    output logic              rf_wr_en,
    output logic [15:0]       rf_wr_data
);
    line_ev_t ev;
    logic     sda_low;
    logic     scl_lvl;
    logic     stop_seen;

    tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    tw_byte_ctrl #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .scl_rise   (ev.scl_rise),
        .scl_fall   (ev.scl_fall),
        .sda_lvl    (ev.sda),
        .start_det  (ev.start),
        .stop_det   (ev.stop),
        .sda_low    (sda_low),
        .rf_addr    (rf_addr),
        .rf_rd_data (rf_rd_data),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_data (rf_wr_data)
    );

    assign sda_oe_n  = ~sda_low;
    assign scl_lvl   = ev.scl;
    assign stop_seen = ev.stop;

endmodule

// File: rtl/tw_reg_target_chk.sv
module tw_reg_target_chk #(
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              stop_seen,
    input logic              sda_oe_n,
    input logic              rf_wr_en,
    input logic [REG_AW-1:0] rf_addr
);
    // R5: the write strobe lasts one cycle
    a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |=> !rf_wr_en);

    // R5: the address does not move while a write is committed
    a_r5_wr_addr_stable: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> $stable(rf_addr));

    // R2 / R6: the target starts pulling SDA only while SCL is low
    a_r2_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_n) |-> !scl_lvl);

    // R1: a STOP releases SDA
    a_r1_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> sda_oe_n);
endmodule

bind tw_reg_target tw_reg_target_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .stop_seen (stop_seen),
    .sda_oe_n  (sda_oe_n),
    .rf_wr_en  (rf_wr_en),
    .rf_addr   (rf_addr)
);

// File: tb/test_tw_reg_target.sv
module test_tw_reg_target;
    localparam int         REG_AW = 4;
    localparam int         NREG   = 1 << REG_AW;
    localparam logic [6:0] DEV    = 7'h52;
    localparam int         Q      = 10;
    localparam int         NVEC   = 10;

    // vector: op(2) reg(4) wdata(16) expected(16); op 0 write, 1 full read, 2 short read
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 4'd3,  16'hBEEF, 16'h0000},
        {2'd1, 4'd3,  16'h0000, 16'hBEEF},
        {2'd2, 4'd0,  16'h0000, 16'hBEEF},
        {2'd0, 4'd7,  16'h0102, 16'h0000},
        {2'd2, 4'd0,  16'h0000, 16'hBEEF},
        {2'd1, 4'd7,  16'h0000, 16'h0102},
        {2'd1, 4'd12, 16'h0000, 16'hC3CC},
        {2'd2, 4'd0,  16'h0000, 16'hC3CC},
        {2'd0, 4'd15, 16'h8001, 16'h0000},
        {2'd1, 4'd15, 16'h0000, 16'h8001}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_oe_n;
    logic              sda_bus;
    logic [REG_AW-1:0] rf_addr;
    logic [15:0]       rf_rd_data;
    logic              rf_wr_en;
    logic [15:0]       rf_wr_data;
    logic [15:0]       regs [NREG];
    int                checks = 0;
    int                errors = 0;
    int                wr_cnt = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus    = sda_m & sda_oe_n;
    assign rf_rd_data = regs[rf_addr];

    tw_reg_target #(.DEV_ADDR(DEV), .REG_AW(REG_AW)) i_tw_reg_target (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_bus),
        .sda_oe_n   (sda_oe_n),
        .rf_addr    (rf_addr),
        .rf_rd_data (rf_rd_data),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_data (rf_wr_data)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'hC300 + 16'(i * 17);
    endfunction

    initial begin
        for (int i = 0; i < NREG; i++) regs[i] = init_val(i);
    end

    always @(posedge clk) begin
        if (rf_wr_en) begin
            regs[rf_addr] <= rf_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bit_in(output logic v);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        v = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_in(v);
            b[i] = v;
        end
        bit_out(~give_ack);
    endtask

    task automatic wr_reg(input logic [3:0] r, input logic [15:0] d, output logic [3:0] acks);
        bus_start();
        send_byte({DEV, 1'b0}, acks[3]);
        send_byte({1'b0, 3'b000, r}, acks[2]);
        send_byte(d[15:8], acks[1]);
        send_byte(d[7:0], acks[0]);
        bus_stop();
    endtask

    task automatic rd_full(input logic [3:0] r, output logic [15:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte({1'b1, 3'b000, r}, acks[1]);
        bus_start();
        send_byte({DEV, 1'b1}, acks[0]);
        recv_byte(d[15:8], 1'b1);
        recv_byte(d[7:0], 1'b0);
        bus_stop();
    endtask

    task automatic rd_short(output logic [15:0] d, output logic acked);
        bus_start();
        send_byte({DEV, 1'b1}, acked);
        recv_byte(d[15:8], 1'b1);
        recv_byte(d[7:0], 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [3:0]  wa;
        logic [2:0]  ra;
        logic        a;
        logic        a2;
        logic [7:0]  b;
        int          wc;

        repeat (4) @(negedge clk);
        // R10: outputs while reset is held
        chk(sda_oe_n === 1'b1, "R10 sda released in reset", {15'h0, sda_oe_n}, 16'h1);
        chk(rf_wr_en === 1'b0, "R10 no write in reset", {15'h0, rf_wr_en}, 16'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R8: short read straight after reset returns register 0
        rd_short(d, a);
        chk(a && d == init_val(0), "R8 pointer resets to register 0", d, init_val(0));
        // R1: STOP leaves SDA released
        chk(sda_oe_n === 1'b1, "R1 released after STOP", {15'h0, sda_oe_n}, 16'h1);

        for (int k = 0; k < NVEC; k++) begin
            logic [37:0] v;
            v = VEC[k];
            case (v[37:36])
                2'd0: begin
                    wr_reg(v[35:32], v[31:16], wa);
                    repeat (2) @(negedge clk);
                    // R2 R4 R5: four acknowledges and the committed word
                    chk(wa == 4'b1111, "R4 write acks", {12'h0, wa}, 16'h000F);
                    chk(regs[v[35:32]] == v[31:16], "R5 write commit", regs[v[35:32]], v[31:16]);
                end
                2'd1: begin
                    rd_full(v[35:32], d, ra);
                    // R2 R6: full read returns the selected register
                    chk(ra == 3'b111 && d == v[15:0], "R6 full read", d, v[15:0]);
                end
                default: begin
                    rd_short(d, a);
                    // R8 R9: short read replays the last full-read register
                    chk(a && d == v[15:0], "R8 short read replay", d, v[15:0]);
                end
            endcase
        end

        // R3: foreign address, then bytes that would be a write
        wc = wr_cnt;
        bus_start();
        send_byte({7'h11, 1'b0}, a);
        chk(!a, "R3 no ack for foreign address", {15'h0, a}, 16'h0);
        send_byte(8'h02, a);
        send_byte(8'h12, a2);
        chk(!a && !a2, "R3 bus ignored after mismatch", {14'h0, a, a2}, 16'h0);
        send_byte(8'h34, a);
        bus_stop();
        repeat (2) @(negedge clk);
        chk(wr_cnt == wc && regs[2] == init_val(2), "R3 no write after mismatch", regs[2], init_val(2));

        // R7: master refuses first byte; target stays silent afterwards
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(b, 1'b0);
        chk(a && b == 8'h80, "R7 first byte before NACK", {8'h0, b}, 16'h0080);
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R7 no data after NACK", {8'h0, b}, 16'h00FF);
        bus_stop();

        // R9: read command closed by STOP does not move the pointer
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({1'b1, 3'b000, 4'd5}, a2);
        bus_stop();
        chk(a && a2, "R4 read command acked", {14'h0, a, a2}, 16'h3);
        rd_short(d, a);
        chk(a && d == 16'h8001, "R9 pointer kept after aborted read", d, 16'h8001);

        // R5: STOP after the first data byte writes nothing
        wc = wr_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte({1'b0, 3'b000, 4'd4}, a);
        send_byte(8'h55, a);
        bus_stop();
        repeat (2) @(negedge clk);
        chk(wr_cnt == wc && regs[4] == init_val(4), "R5 no commit on early STOP", regs[4], init_val(4));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule